// File: doc/BRIEF.md
# Handshake-Protected Multi-Bit Clock Domain Crossing

This block carries a multi-bit binary word, such as a buffer pointer, from one clock domain into another clock domain with no fixed relation to the first. It does not need Gray coding. The source side latches the offered word into a holding register. It keeps that register frozen while a request/acknowledge exchange completes. The exchange has four phases:

1. The request rises.
2. The acknowledge rises.
3. The request falls.
4. The acknowledge falls.

Each control level crosses into the other domain through its own chain of at least two flip-flops. The destination copies the held word only after it sees a rising edge on its synchronized copy of the request. At that point the held word has been stable for several destination cycles.

The source side is a valid/ready stream input. A word is taken on a rising source clock edge when `src_valid` and `src_ready` are both high. `src_ready` is low for the whole exchange, so it doubles as the busy indication. An upstream producer that holds `src_valid` high waits for `src_ready`. A producer that only ever offers its latest value, for example a pointer that keeps moving, can change `src_data` freely while it waits. Only the value present at the accepting edge travels. The destination side has no back-pressure. It presents a register, `dst_data`, together with a one-cycle strobe, `dst_update`, on every delivery.

The delivered word can lag the live source value by one full exchange. For pointer exchange, this lag can only make a full or empty indication appear early, never late.

Top module: `hs_cdc_bridge`

## Requirements
- R1: While its own reset is high and on the first clock after it falls, each domain shows its idle state: `src_ready` is 1, `dst_update` is 0 and `dst_data` is all zeros.
- R2: A word is accepted on a rising `src_clk` edge where `src_valid` and `src_ready` are both 1, and `src_ready` is 0 from the following source cycle.
- R3: The internal holding register does not change while a transfer is in progress (`src_ready` low).
- R4: Every word presented on `dst_data` with `dst_update` high is bit-for-bit equal to a word accepted at the source.
- R5: Every accepted word is delivered exactly once, and deliveries occur in acceptance order.
- R6: `dst_update` is high for exactly one `dst_clk` cycle per delivery, and `dst_data` changes only in the cycle in which `dst_update` is high.
- R7: While `src_ready` is low, `src_valid` and `src_data` have no effect, and a word offered then is never delivered.
- R8: The handshake runs in four-phase order. The request falls only after the synchronized acknowledge has been seen high. The acknowledge falls only after the synchronized request has been seen low. `src_ready` returns to 1 only after the previously accepted word has been delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Source domain reset, active high, synchronous |
| src_valid | input | 1 | Source offers `src_data` |
| src_ready | output | 1 | Source can accept a word; low while a transfer is busy |
| src_data | input | WIDTH | Word offered by the source |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst | input | 1 | Destination domain reset, active high, synchronous |
| dst_data | output | WIDTH | Last word delivered into the destination domain |
| dst_update | output | 1 | One-cycle strobe marking a new delivery on `dst_data` |

## Verification
The assertions assume that each reset is applied for at least a few cycles of its own clock. They also assume that both resets are released while no transfer is in flight, so that neither side holds a stale request or acknowledge from the other. The stimulus asserts both resets together from time zero, for well over the synchronizer depth, and releases them before any word is offered. The source inputs change only on falling source clock edges, so every acceptance is decided on a clean rising edge. The two clocks run at unrelated periods, so the sampling phase of each synchronizer drifts across the run.

// File: rtl/hs_cdc_pkg.sv
package hs_cdc_pkg;
  localparam int unsigned MIN_SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_REQ  = 2'd1,
    SRC_DROP = 2'd2
  } src_state_e;
endpackage

// File: rtl/hs_sync_chain.sv
module hs_sync_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int unsigned DEPTH = (STAGES < hs_cdc_pkg::MIN_SYNC_STAGES) ?
                                  hs_cdc_pkg::MIN_SYNC_STAGES : STAGES;

  logic [DEPTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[DEPTH-2:0], d};
  end

  assign q = chain_q[DEPTH-1];
endmodule

// File: rtl/hs_src_side.sv
module hs_src_side #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  input  logic             ack_sync,
  output logic             req,
  output logic [WIDTH-1:0] hold
);
  import hs_cdc_pkg::*;

  src_state_e       state_q;
  logic             req_q;
  logic [WIDTH-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SRC_IDLE;
      req_q   <= 1'b0;
      hold_q  <= '0;
    end else begin
      unique case (state_q)
        SRC_IDLE: if (in_valid) begin
          hold_q  <= in_data;
          req_q   <= 1'b1;
          state_q <= SRC_REQ;
        end
        SRC_REQ: if (ack_sync) begin
          req_q   <= 1'b0;
          state_q <= SRC_DROP;
        end
        SRC_DROP: if (!ack_sync) state_q <= SRC_IDLE;
        default: state_q <= SRC_IDLE;
      endcase
    end
  end

  assign in_ready = (state_q == SRC_IDLE);
  assign req      = req_q;
  assign hold     = hold_q;

  a_r2_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  a_r3_hold_stable: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> $stable(hold_q));

  a_r8_req_falls_after_ack: assert property (@(posedge clk) disable iff (rst)
    $fell(req_q) |-> $past(ack_sync));

  a_r8_ready_after_ack_low: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ready) |-> $past(!ack_sync));
endmodule

// File: rtl/hs_dst_side.sv
module hs_dst_side #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_sync,
  input  logic [WIDTH-1:0] hold,
  output logic             ack,
  output logic [WIDTH-1:0] out_data,
  output logic             out_update
);
  logic             req_seen_q;
  logic             ack_q;
  logic             upd_q;
  logic [WIDTH-1:0] data_q;
  logic             req_edge;

  assign req_edge = req_sync && !req_seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_seen_q <= 1'b0;
      ack_q      <= 1'b0;
      upd_q      <= 1'b0;
      data_q     <= '0;
    end else begin
      req_seen_q <= req_sync;
      upd_q      <= req_edge;
      if (req_edge) begin
        data_q <= hold;
        ack_q  <= 1'b1;
      end else if (!req_sync) begin
        ack_q  <= 1'b0;
      end
    end
  end

  assign ack        = ack_q;
  assign out_data   = data_q;
  assign out_update = upd_q;

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_update |=> !out_update);

  a_r6_data_only_on_update: assert property (@(posedge clk) disable iff (rst)
    !out_update |-> $stable(data_q));

  a_r8_ack_falls_after_req_low: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_q) |-> $past(!req_sync));

  a_r8_ack_rises_with_update: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_q) |-> out_update);
endmodule

// File: rtl/hs_cdc_bridge.sv
module hs_cdc_bridge #(
  parameter int unsigned WIDTH       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             src_clk,
  input  logic             src_rst,
  input  logic             src_valid,
  output logic             src_ready,
  input  logic [WIDTH-1:0] src_data,
  input  logic             dst_clk,
  input  logic             dst_rst,
  output logic [WIDTH-1:0] dst_data,
  output logic             dst_update
);
  logic             req_w;
  logic             ack_w;
  logic             req_at_dst;
  logic             ack_at_src;
  logic [WIDTH-1:0] hold_w;

  hs_src_side #(.WIDTH(WIDTH)) src_i (
    .clk(src_clk), .rst(src_rst),
    .in_valid(src_valid), .in_ready(src_ready), .in_data(src_data),
    .ack_sync(ack_at_src), .req(req_w), .hold(hold_w)
  );

  hs_sync_chain #(.STAGES(SYNC_STAGES)) req_sync_i (
    .clk(dst_clk), .rst(dst_rst), .d(req_w), .q(req_at_dst)
  );

  hs_sync_chain #(.STAGES(SYNC_STAGES)) ack_sync_i (
    .clk(src_clk), .rst(src_rst), .d(ack_w), .q(ack_at_src)
  );

  hs_dst_side #(.WIDTH(WIDTH)) dst_i (
    .clk(dst_clk), .rst(dst_rst),
    .req_sync(req_at_dst), .hold(hold_w), .ack(ack_w),
    .out_data(dst_data), .out_update(dst_update)
  );
endmodule

// File: tb/hs_cdc_bridge_tb.sv
`timescale 1ps/1ps
module hs_cdc_bridge_tb_top;
  localparam int W = 16;

  logic         src_clk = 1'b0;
  logic         dst_clk = 1'b0;
  logic         src_rst = 1'b1;
  logic         dst_rst = 1'b1;
  logic         src_valid = 1'b0;
  logic [W-1:0] src_data = '0;
  logic         src_ready;
  logic [W-1:0] dst_data;
  logic         dst_update;

  always #2500 src_clk = ~src_clk;
  always #3650 dst_clk = ~dst_clk;

  hs_cdc_bridge #(.WIDTH(W), .SYNC_STAGES(2)) dut_i (
    .src_clk(src_clk), .src_rst(src_rst), .src_valid(src_valid),
    .src_ready(src_ready), .src_data(src_data),
    .dst_clk(dst_clk), .dst_rst(dst_rst),
    .dst_data(dst_data), .dst_update(dst_update)
  );

  int checks = 0;
  int errors = 0;
  int accepted = 0;
  int delivered = 0;
  bit running = 0;
  bit finished = 0;
  logic [W-1:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pattern(input int i);
    case (i)
      0: return '1;
      1: return '0;
      2: return {W/2{2'b10}};
      default: return W'(i * 16'h1357 + 16'h00a5);
    endcase
  endfunction

  // destination monitor (R4, R5, R6)
  logic [W-1:0] last_data = '0;
  bit prev_upd = 0;
  always @(negedge dst_clk) if (running) begin
    if (dst_update) begin
      if (exp_q.size() == 0) chk(0, "R5 unexpected delivery", dst_data, 0);
      else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        chk(dst_data == e, "R4/R5 delivered word", dst_data, e);
      end
      delivered++;
      if (prev_upd) chk(0, "R6 strobe longer than one cycle", 1, 0);
      last_data = dst_data;
    end else if (dst_data != last_data) begin
      chk(0, "R6 data changed without strobe", dst_data, last_data);
      last_data = dst_data;
    end
    prev_upd = dst_update;
  end

  task automatic drive_run(input int n, input int mode);
    bit prev_valid = 0;
    bit prev_ready = 0;
    bit ready_last = 1;
    logic [W-1:0] prev_word = '0;
    int sent = 0;
    int idx = 0;
    while (sent < n) begin
      @(negedge src_clk);
      if (prev_valid && prev_ready) begin
        exp_q.push_back(prev_word);
        accepted++;
        sent++;
        chk(src_ready == 1'b0, "R2 ready low after accept", src_ready, 0);
      end
      if (src_ready && !ready_last)
        chk(delivered == accepted, "R8 ready before delivery", delivered, accepted);
      ready_last = src_ready;
      prev_ready = src_ready;
      case (mode)
        0: src_valid = 1'b1;
        default: src_valid = ($urandom % 2) == 0;
      endcase
      // R7: words offered while busy carry a marker and must never appear
      if (!src_ready) src_data = 16'hdead;
      else if (mode == 0) src_data = pattern(idx++);
      else src_data = W'($urandom);
      prev_valid = src_valid;
      prev_word  = src_data;
    end
    @(negedge src_clk);
    src_valid = 1'b0;
  endtask

  initial begin
    process::self().srandom(32'h5eed_1234);
    repeat (6) @(negedge src_clk);
    // R1 during reset
    chk(src_ready == 1'b1, "R1 src_ready in reset", src_ready, 1);
    chk(dst_update == 1'b0, "R1 dst_update in reset", dst_update, 0);
    chk(dst_data == '0, "R1 dst_data in reset", dst_data, 0);
    src_rst = 1'b0;
    dst_rst = 1'b0;
    @(negedge src_clk);
    @(negedge dst_clk);
    chk(src_ready == 1'b1, "R1 src_ready after reset", src_ready, 1);
    chk(dst_update == 1'b0, "R1 dst_update after reset", dst_update, 0);
    chk(dst_data == '0, "R1 dst_data after reset", dst_data, 0);
    running = 1;
    drive_run(40, 0);   // back-to-back valid with directed corner words
    drive_run(250, 1);  // random valid
    repeat (60) @(negedge src_clk);
    chk(exp_q.size() == 0, "R5 all accepted words delivered", exp_q.size(), 0);
    chk(delivered == accepted, "R5 delivery count", delivered, accepted);
    chk(src_ready == 1'b1, "R8 idle after drain", src_ready, 1);
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge src_clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule